// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder and Control Unit

This block turns one 32-bit instruction word of a small 8-bit single-cycle processor into the control signals for the rest of the datapath. It picks the register-file read and write addresses out of the instruction. It chooses the ALU operation and says whether operand 2 comes from a register or from the immediate byte. It also flags subtraction, so that the datapath can feed the negated operand 2 into the adder. Finally it decides whether the program counter leaves the sequential path, and by how far.

The instruction word has four bytes. Bits 31:24 hold the opcode, bits 23:16 the destination field, bits 15:8 the first source field and bits 7:0 the second source field. The instruction set is loadi, mov, add, sub, and, or, j and beq. The ALU's zero flag is the only other input, and beq uses it to decide whether to branch. The block is purely combinational, so every output settles within the same cycle as the instruction.

Top module: `ctl_decode_top`

## Requirements
- R1: The register addresses are the low log2(NUM_REGS) bits (3 by default) of each field: destination bits 23:16 give `rd_addr`, bits 15:8 give `rs1_addr` and bits 7:0 give `rs2_addr`. The upper bits of each field have no effect on these addresses.
- R2: `alu_sel` is 000 (forward operand 2) for loadi (opcode 0x00) and mov (0x01). It is 001 (add) for add (0x02), sub (0x03) and beq (0x07). It is 010 (AND) for and (0x04), 011 (OR) for or (0x05), and 000 for j (0x06) and for every other opcode.
- R3: `negate_b` is high only for sub and beq.
- R4: `use_imm` is high only for loadi, and `imm_val` always equals instruction bits 7:0.
- R5: `reg_wr_en` is high for loadi, mov, add, sub, and and or. It is low for j, for beq and for every undefined opcode (0x08 to 0xFF).
- R6: `pc_redirect` is high for j, whatever the value of `alu_zero`.
- R7: For beq, `pc_redirect` equals `alu_zero`. For every opcode other than j and beq, `pc_redirect` is low.
- R8: `branch_ofs` equals instruction bits 23:16. `pc_byte_ofs` is that byte taken as a signed value and multiplied by 4, in two's complement of width OFS_W (11 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Current instruction word |
| alu_zero | input | 1 | ALU result-is-zero flag |
| rd_addr | output | 3 | Register write address |
| rs1_addr | output | 3 | First register read address |
| rs2_addr | output | 3 | Second register read address |
| imm_val | output | 8 | Immediate byte |
| reg_wr_en | output | 1 | Register-file write enable |
| alu_sel | output | 3 | ALU operation select |
| use_imm | output | 1 | Operand 2 taken from the immediate |
| negate_b | output | 1 | Feed the two's complement of operand 2 into the adder |
| pc_redirect | output | 1 | Next PC is PC+4 plus the byte offset |
| branch_ofs | output | 8 | Raw signed word offset |
| pc_byte_ofs | output | 11 | Sign-extended offset scaled by 4 |

## Verification
No register lies between any input and any output, so each result is due in the same cycle as the instruction and zero flag that produce it. The bench applies each stimulus away from the clock edge and waits a short settling delay before it samples. It never waits a clock cycle. It sweeps all 256 opcodes against both values of the zero flag and several field patterns. It also sweeps every offset byte, and it computes each expected value arithmetically.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
   localparam int BYTE_W  = 8;
   localparam int INSTR_W = 4 * BYTE_W;

   typedef enum logic [BYTE_W-1:0] {
      OPC_LOADI = 8'h00,
      OPC_MOV   = 8'h01,
      OPC_ADD   = 8'h02,
      OPC_SUB   = 8'h03,
      OPC_AND   = 8'h04,
      OPC_OR    = 8'h05,
      OPC_JMP   = 8'h06,
      OPC_BEQ   = 8'h07
   } opcode_e;

   typedef enum logic [2:0] {
      ALU_FWD = 3'b000,
      ALU_ADD = 3'b001,
      ALU_AND = 3'b010,
      ALU_OR  = 3'b011
   } alu_sel_e;

   typedef struct packed {
      logic       wr_en;
      logic [2:0] alu_sel;
      logic       use_imm;
      logic       negate;
      logic       is_jump;
      logic       is_beq;
   } ctl_t;
endpackage

// File: rtl/ctl_fields.sv
module ctl_fields
   import ctl_pkg::*;
#(
   parameter int REG_AW = 3
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [BYTE_W-1:0]  opcode,
   output logic [REG_AW-1:0]  rd_addr,
   output logic [REG_AW-1:0]  rs1_addr,
   output logic [REG_AW-1:0]  rs2_addr,
   output logic [BYTE_W-1:0]  imm_val,
   output logic [BYTE_W-1:0]  ofs_raw
);
   localparam int OPC_LSB = 3 * BYTE_W;
   localparam int DST_LSB = 2 * BYTE_W;
   localparam int SR1_LSB = BYTE_W;
   localparam int SR2_LSB = 0;

   always_comb begin
      opcode   = instr[OPC_LSB +: BYTE_W];
      rd_addr  = instr[DST_LSB +: REG_AW];
      rs1_addr = instr[SR1_LSB +: REG_AW];
      rs2_addr = instr[SR2_LSB +: REG_AW];
      imm_val  = instr[SR2_LSB +: BYTE_W];
      ofs_raw  = instr[DST_LSB +: BYTE_W];
   end
endmodule

// File: rtl/ctl_opdec.sv
module ctl_opdec
   import ctl_pkg::*;
(
   input  logic [BYTE_W-1:0] opcode,
   output ctl_t              ctl
);
   always_comb begin
      ctl = '0;
      case (opcode)
         OPC_LOADI: begin ctl.wr_en = 1'b1; ctl.alu_sel = ALU_FWD; ctl.use_imm = 1'b1; end
         OPC_MOV:   begin ctl.wr_en = 1'b1; ctl.alu_sel = ALU_FWD; end
         OPC_ADD:   begin ctl.wr_en = 1'b1; ctl.alu_sel = ALU_ADD; end
         OPC_SUB:   begin ctl.wr_en = 1'b1; ctl.alu_sel = ALU_ADD; ctl.negate = 1'b1; end
         OPC_AND:   begin ctl.wr_en = 1'b1; ctl.alu_sel = ALU_AND; end
         OPC_OR:    begin ctl.wr_en = 1'b1; ctl.alu_sel = ALU_OR;  end
         OPC_JMP:   begin ctl.is_jump = 1'b1; end
         OPC_BEQ:   begin ctl.alu_sel = ALU_ADD; ctl.negate = 1'b1; ctl.is_beq = 1'b1; end
         default:   ctl = '0;
      endcase
   end
endmodule

// File: rtl/ctl_nextpc.sv
module ctl_nextpc
   import ctl_pkg::*;
#(
   parameter int OFS_SHIFT = 2,
   parameter int OFS_W     = 11
) (
   input  logic              is_jump,
   input  logic              is_beq,
   input  logic              alu_zero,
   input  logic [BYTE_W-1:0] ofs_raw,
   output logic              redirect,
   output logic [OFS_W-1:0]  byte_ofs
);
   localparam int PAD = OFS_W - BYTE_W - OFS_SHIFT;

   if (OFS_SHIFT < 1) begin : g_bad_shift
      $error("ctl_nextpc: OFS_SHIFT must be at least 1");
   end
   if (PAD < 0) begin : g_bad_width
      $error("ctl_nextpc: OFS_W too narrow for the scaled offset");
   end

   if (PAD > 0) begin : g_ext
      assign byte_ofs = {{PAD{ofs_raw[BYTE_W-1]}}, ofs_raw, {OFS_SHIFT{1'b0}}};
   end else begin : g_exact
      assign byte_ofs = {ofs_raw, {OFS_SHIFT{1'b0}}};
   end

   always_comb redirect = is_jump | (is_beq & alu_zero);
endmodule

// File: rtl/ctl_decode_top.sv
module ctl_decode_top
   import ctl_pkg::*;
#(
   parameter int NUM_REGS  = 8,
   parameter int OFS_SHIFT = 2,
   parameter int OFS_W     = 11,
   localparam int REG_AW   = $clog2(NUM_REGS)
) (
   input  logic [31:0]       instr,
   input  logic              alu_zero,
   output logic [REG_AW-1:0] rd_addr,
   output logic [REG_AW-1:0] rs1_addr,
   output logic [REG_AW-1:0] rs2_addr,
   output logic [7:0]        imm_val,
   output logic              reg_wr_en,
   output logic [2:0]        alu_sel,
   output logic              use_imm,
   output logic              negate_b,
   output logic              pc_redirect,
   output logic [7:0]        branch_ofs,
   output logic [OFS_W-1:0]  pc_byte_ofs
);
   if (NUM_REGS < 2 || NUM_REGS > 256 || (1 << REG_AW) != NUM_REGS) begin : g_bad_regs
      $error("ctl_decode_top: NUM_REGS must be a power of two from 2 to 256");
   end

   logic [BYTE_W-1:0] opcode;
   ctl_t              ctl;

   ctl_fields #(.REG_AW(REG_AW)) u_fields (
      .instr   (instr),
      .opcode  (opcode),
      .rd_addr (rd_addr),
      .rs1_addr(rs1_addr),
      .rs2_addr(rs2_addr),
      .imm_val (imm_val),
      .ofs_raw (branch_ofs)
   );

   ctl_opdec u_opdec (
      .opcode(opcode),
      .ctl   (ctl)
   );

   ctl_nextpc #(.OFS_SHIFT(OFS_SHIFT), .OFS_W(OFS_W)) u_nextpc (
      .is_jump (ctl.is_jump),
      .is_beq  (ctl.is_beq),
      .alu_zero(alu_zero),
      .ofs_raw (branch_ofs),
      .redirect(pc_redirect),
      .byte_ofs(pc_byte_ofs)
   );

   always_comb begin
      reg_wr_en = ctl.wr_en;
      alu_sel   = ctl.alu_sel;
      use_imm   = ctl.use_imm;
      negate_b  = ctl.negate;
   end

   always_comb begin
      AST_WR_NO_REDIRECT: assert (!(reg_wr_en && pc_redirect));          // R5
      AST_SEL_IN_RANGE:   assert (alu_sel[2] == 1'b0);                   // R2
      AST_NEG_USES_ADD:   assert (!negate_b || alu_sel == ALU_ADD);      // R3
      AST_IMM_NOT_NEG:    assert (!(use_imm && negate_b));               // R4
      AST_REDIR_OPCODE:   assert (!pc_redirect || opcode == OPC_JMP || opcode == OPC_BEQ); // R7
      AST_OFS_TRACKS_RAW: assert (pc_byte_ofs[OFS_SHIFT +: 8] == branch_ofs); // R8
   end
endmodule

// File: tb/tb_ctl_decode_top.sv
module tb_ctl_decode_top;
   logic        clk = 1'b0;
   logic [31:0] instr = '0;
   logic        alu_zero = 1'b0;
   logic [2:0]  rd_addr, rs1_addr, rs2_addr, alu_sel;
   logic [7:0]  imm_val, branch_ofs;
   logic        reg_wr_en, use_imm, negate_b, pc_redirect;
   logic [10:0] pc_byte_ofs;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   ctl_decode_top dut (
      .instr(instr), .alu_zero(alu_zero), .rd_addr(rd_addr), .rs1_addr(rs1_addr),
      .rs2_addr(rs2_addr), .imm_val(imm_val), .reg_wr_en(reg_wr_en), .alu_sel(alu_sel),
      .use_imm(use_imm), .negate_b(negate_b), .pc_redirect(pc_redirect),
      .branch_ofs(branch_ofs), .pc_byte_ofs(pc_byte_ofs)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] w, input logic z);
      @(negedge clk);
      instr = w;
      alu_zero = z;
      #1;
   endtask

   initial begin
      #1;
      // idle state: all-zero word decodes as loadi r0, imm 0
      chk("R5 idle wr_en", int'(reg_wr_en), 1);
      chk("R7 idle redirect", int'(pc_redirect), 0);
      chk("R4 idle use_imm", int'(use_imm), 1);

      for (int op = 0; op < 256; op++) begin
         for (int z = 0; z < 2; z++) begin
            for (int p = 0; p < 3; p++) begin
               logic [7:0] d, s1, s2;
               int e_sel, e_neg, e_imm, e_wr, e_red;
               d  = (p == 0) ? 8'hF5 : (p == 1) ? 8'h0A : 8'h83;
               s1 = (p == 0) ? 8'h3B : (p == 1) ? 8'hC6 : 8'h71;
               s2 = (p == 0) ? 8'hEC : (p == 1) ? 8'h17 : 8'h5A;
               apply({op[7:0], d, s1, s2}, z[0]);
               e_sel = (op == 2 || op == 3 || op == 7) ? 1 : (op == 4) ? 2 : (op == 5) ? 3 : 0;
               e_neg = (op == 3 || op == 7) ? 1 : 0;
               e_imm = (op == 0) ? 1 : 0;
               e_wr  = (op <= 5) ? 1 : 0;
               e_red = (op == 6) ? 1 : (op == 7) ? z : 0;
               chk("R1 rd_addr", int'(rd_addr), int'(d) % 8);
               chk("R1 rs1_addr", int'(rs1_addr), int'(s1) % 8);
               chk("R1 rs2_addr", int'(rs2_addr), int'(s2) % 8);
               chk("R2 alu_sel", int'(alu_sel), e_sel);
               chk("R3 negate_b", int'(negate_b), e_neg);
               chk("R4 use_imm", int'(use_imm), e_imm);
               chk("R4 imm_val", int'(imm_val), int'(s2));
               chk("R5 reg_wr_en", int'(reg_wr_en), e_wr);
               if (op == 6) chk("R6 jump redirect", int'(pc_redirect), e_red);
               else         chk("R7 redirect", int'(pc_redirect), e_red);
            end
         end
      end

      for (int d = 0; d < 256; d++) begin
         int sv, e_ofs;
         sv = (d >= 128) ? d - 256 : d;
         e_ofs = (sv * 4) & 11'h7FF;
         apply({8'h07, d[7:0], 8'h00, 8'h00}, 1'b1);
         chk("R8 branch_ofs", int'(branch_ofs), d);
         chk("R8 pc_byte_ofs", int'(pc_byte_ofs), e_ofs);
         chk("R7 beq taken", int'(pc_redirect), 1);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule